// File: doc/BRIEF.md
# Receive FIFO with Fill Threshold and Idle Timeout

This block is the receive-side byte buffer of a 16550-class asynchronous serial receiver. A deserialiser upstream pushes each completed character together with three error indications (parity error, framing error, break). Register reads downstream pop the oldest entry. The buffer holds up to sixteen entries, and it always presents the oldest one with its flags at the head outputs.

Two requests go to the interrupt logic. The fill-threshold request is high while the number of stored bytes is at or above a level that two select bits choose. The idle-timeout request rises when data has sat in the buffer for four character times with no push and no pop. An aggregate error flag tells the line-status logic that at least one stored entry carries an error. When FIFO mode is off, the buffer acts as a one-entry holding register. Pushing into a full buffer leaves the stored data intact and produces a one-cycle overrun pulse.

Top module: `rx_fifo_trig`

## Requirements
- R1: Entries leave in arrival order. While the fill count is nonzero, `head_data`/`head_perr`/`head_ferr`/`head_brk` show the oldest stored entry. In FIFO mode sixteen entries can be held at once.
- R2: `fill_cnt` gives the number of stored entries, updated the cycle after each accepted push or pop. After reset, `fill_cnt`, `trig_req`, `tmo_req`, `err_any` and `overrun` are all 0.
- R3: In FIFO mode, `trig_sel` encodes the threshold: 2'b00 → 1, 2'b01 → 4, 2'b10 → 8, 2'b11 → 14 bytes. `trig_req` is high exactly while `fill_cnt` is greater than or equal to the threshold.
- R4: With `fifo_en` low, the buffer holds at most one entry, the threshold is 1 whatever `trig_sel` is, and `tmo_req` stays low.
- R5: In FIFO mode, `tmo_req` goes high in the cycle after the fourth `char_tick` that falls in a stretch where the buffer is nonempty and no byte has been pushed or popped.
- R6: Any accepted push or pop restarts the idle count, and the count stays at zero while the buffer is empty. A pop drops `tmo_req` in the following cycle.
- R7: `err_any` is set the cycle after a byte with any error flag is accepted. `lsr_read` clears it unless an errored byte is accepted in the same cycle. It also drops once no stored entry carries an error.
- R8: `rx_flush` empties the buffer and clears the idle count, `err_any` and `overrun`. A push or pop in the same cycle is discarded.
- R9: A push while the buffer is at capacity, with no pop in the same cycle, is not stored and gives `overrun` = 1 for exactly the next cycle. A push together with a pop at capacity is accepted.
- R10: Any change of `fifo_en` empties the buffer, just as `rx_flush` does.
- R11: A pop while the buffer is empty has no effect: `fill_cnt` stays 0 and later pushes are stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: sixteen-entry FIFO mode, 0: single holding register |
| trig_sel | input | 2 | Fill-threshold select |
| rx_flush | input | 1 | Empty the buffer (one-cycle strobe) |
| push | input | 1 | Store a received character |
| push_data | input | 8 | Received byte |
| push_perr | input | 1 | Parity error of the received byte |
| push_ferr | input | 1 | Framing error of the received byte |
| push_brk | input | 1 | Break indication of the received byte |
| pop | input | 1 | Remove the head entry |
| lsr_read | input | 1 | Line-status read strobe, clears the error flag |
| char_tick | input | 1 | One pulse per character time |
| head_data | output | 8 | Oldest stored byte |
| head_perr | output | 1 | Parity error of the head entry |
| head_ferr | output | 1 | Framing error of the head entry |
| head_brk | output | 1 | Break indication of the head entry |
| fill_cnt | output | 5 | Number of stored entries |
| trig_req | output | 1 | Fill count at or above the threshold |
| tmo_req | output | 1 | Idle-timeout request |
| err_any | output | 1 | Some stored entry carries an error |
| overrun | output | 1 | One-cycle pulse on a rejected push |

## Verification
The hardest state to reach is a timeout that must not fire. Three character ticks are followed by a push that restarts the count, and a further three ticks must still leave the request low. The directed stimulus builds that sequence tick by tick. The error flag is exercised the same way: an errored byte is buried between clean ones, cleared by a status read, and then allowed to drain away. A long randomised phase follows. It mixes pushes at capacity, simultaneous push and pop, rare flushes and mode changes, and compares every output each cycle against a queue-based model.

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
  parameter int DEPTH     = 16,
  parameter int TRIG_01   = 4,
  parameter int TRIG_10   = 8,
  parameter int TRIG_11   = 14,
  parameter int TMO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic [1:0] trig_sel,
  input  logic       rx_flush,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       push_perr,
  input  logic       push_ferr,
  input  logic       push_brk,
  input  logic       pop,
  input  logic       lsr_read,
  input  logic       char_tick,
  output logic [7:0] head_data,
  output logic       head_perr,
  output logic       head_ferr,
  output logic       head_brk,
  output logic [4:0] fill_cnt,
  output logic       trig_req,
  output logic       tmo_req,
  output logic       err_any,
  output logic       overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int IW = $clog2(TMO_CHARS + 1);

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, err_cnt, thr;
  logic [IW-1:0] idle;
  logic          en_q, err_q, ovr_q;

  wire           flush    = rx_flush | (fifo_en ^ en_q);
  wire [CW-1:0]  cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  wire           pop_ok   = pop & (cnt != '0);
  wire           push_ok  = push & ((cnt < cap) | pop_ok);
  wire [10:0]    head     = mem[rd_ptr];
  wire           head_err = |head[10:8];
  wire           in_err   = push_perr | push_ferr | push_brk;
  wire [CW-1:0]  err_nxt  = err_cnt + CW'(push_ok & in_err) - CW'(pop_ok & head_err);

  always_comb begin
    thr = CW'(1);
    if (fifo_en)
      case (trig_sel)
        2'b01:   thr = CW'(TRIG_01);
        2'b10:   thr = CW'(TRIG_10);
        2'b11:   thr = CW'(TRIG_11);
        default: thr = CW'(1);
      endcase
  end

  always_ff @(posedge clk)
    if (push_ok && !flush) mem[wr_ptr] <= {push_brk, push_ferr, push_perr, push_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0; err_cnt <= '0;
      idle <= '0; en_q <= 1'b0; err_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      en_q <= fifo_en;
      if (flush) begin
        wr_ptr <= '0; rd_ptr <= '0; cnt <= '0; err_cnt <= '0;
        idle <= '0; err_q <= 1'b0; ovr_q <= 1'b0;
      end else begin
        if (push_ok) wr_ptr <= wr_ptr + 1'b1;
        if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        cnt     <= cnt + CW'(push_ok) - CW'(pop_ok);
        err_cnt <= err_nxt;
        ovr_q   <= push & ~push_ok;
        if (cnt == '0 || push_ok || pop_ok)                 idle <= '0;
        else if (char_tick && idle != IW'(TMO_CHARS))      idle <= idle + 1'b1;
        if (err_nxt == '0)             err_q <= 1'b0;
        else if (push_ok && in_err)    err_q <= 1'b1;
        else if (lsr_read)             err_q <= 1'b0;
      end
    end
  end

  assign {head_brk, head_ferr, head_perr, head_data} = head;
  assign fill_cnt = 5'(cnt);
  assign trig_req = cnt >= thr;
  assign tmo_req  = fifo_en & (idle == IW'(TMO_CHARS));
  assign err_any  = err_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       rx_flush,
  input logic       push,
  input logic       pop,
  input logic [4:0] fill_cnt,
  input logic       trig_req,
  input logic       tmo_req,
  input logic       err_any,
  input logic       overrun
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= 5'(DEPTH)); // R1
  AST_TRIG_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt == 5'd0 |-> !trig_req); // R3
  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !$past(fifo_en)) |-> fill_cnt <= 5'd1); // R4
  AST_TMO_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_req |-> fill_cnt != 5'd0); // R5
  AST_POP_DROPS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fill_cnt != 5'd0 && !rx_flush) |=> !tmo_req); // R6
  AST_ERR_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> fill_cnt != 5'd0); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (fill_cnt == 5'd0 && !err_any && !overrun)); // R8
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(push) && !$past(rx_flush) && $past(fill_cnt) != 5'd0)); // R9
endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_flush(rx_flush),
  .push(push), .pop(pop), .fill_cnt(fill_cnt), .trig_req(trig_req),
  .tmo_req(tmo_req), .err_any(err_any), .overrun(overrun)
);

// File: tb/rx_fifo_trig_tb_top.sv
`timescale 1ns/1ps
module rx_fifo_trig_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 1'b0, rx_flush = 1'b0, push = 1'b0, pop = 1'b0;
  logic lsr_read = 1'b0, char_tick = 1'b0;
  logic push_perr = 1'b0, push_ferr = 1'b0, push_brk = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic [7:0] push_data = 8'h00;
  logic [7:0] head_data;
  logic head_perr, head_ferr, head_brk, trig_req, tmo_req, err_any, overrun;
  logic [4:0] fill_cnt;

  rx_fifo_trig dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .rx_flush(rx_flush), .push(push), .push_data(push_data),
    .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
    .pop(pop), .lsr_read(lsr_read), .char_tick(char_tick),
    .head_data(head_data), .head_perr(head_perr), .head_ferr(head_ferr),
    .head_brk(head_brk), .fill_cnt(fill_cnt), .trig_req(trig_req),
    .tmo_req(tmo_req), .err_any(err_any), .overrun(overrun)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc_n = 0;
  bit cmp_on = 1'b0;

  logic [10:0] q[$];
  int idle_m = 0;
  bit eflag_m = 0, ovr_m = 0, fen_m = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int thr_m();
    if (!fifo_en) return 1;
    case (trig_sel)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); idle_m = 0; eflag_m = 0; ovr_m = 0; fen_m = 0;
    end else begin
      bit fl, popok, pushok, was_empty, errin;
      int cap, ne;
      fl = rx_flush || (fifo_en != fen_m);
      fen_m = fifo_en;
      cap = fifo_en ? 16 : 1;
      if (fl) begin
        q.delete(); idle_m = 0; eflag_m = 0; ovr_m = 0;
      end else begin
        errin = push_perr | push_ferr | push_brk;
        popok = pop && q.size() > 0;
        pushok = push && (q.size() < cap || popok);
        was_empty = q.size() == 0;
        if (popok) void'(q.pop_front());
        if (pushok) q.push_back({push_brk, push_ferr, push_perr, push_data});
        ovr_m = push && !pushok;
        if (was_empty || pushok || popok) idle_m = 0;
        else if (char_tick && idle_m < 4) idle_m++;
        ne = 0;
        foreach (q[i]) if (q[i][10:8] != 3'b000) ne++;
        if (ne == 0) eflag_m = 0;
        else if (pushok && errin) eflag_m = 1;
        else if (lsr_read) eflag_m = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R2 fill_cnt", 16'(fill_cnt), 16'(q.size()));
      if (q.size() > 0)
        chk("R1 head entry", {5'd0, head_brk, head_ferr, head_perr, head_data}, {5'd0, q[0]});
      chk(fifo_en ? "R3 trig_req" : "R4 trig_req", 16'(trig_req), 16'(q.size() >= thr_m()));
      chk("R5 tmo_req", 16'(tmo_req), 16'(fifo_en && idle_m == 4));
      chk("R7 err_any", 16'(err_any), 16'(eflag_m));
      chk("R9 overrun", 16'(overrun), 16'(ovr_m));
    end
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cyc(bit p, logic [10:0] e, bit pp, bit tk, bit lr, bit fl);
    push = p; {push_brk, push_ferr, push_perr, push_data} = e;
    pop = pp; char_tick = tk; lsr_read = lr; rx_flush = fl;
    @(posedge clk); #2;
  endtask

  task automatic nop();
    cyc(0, 11'h0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    #2;
    chk("R2 reset fill_cnt", 16'(fill_cnt), 16'd0);
    chk("R2 reset requests", {12'd0, trig_req, tmo_req, err_any, overrun}, 16'd0);
    cmp_on = 1'b1;

    // R4: holding-register mode
    trig_sel = 2'b11;
    cyc(1, 11'h0A1, 0, 0, 0, 0);
    cyc(1, 11'h0B2, 0, 0, 0, 0);
    chk("R4 single entry", 16'(fill_cnt), 16'd1);
    chk("R9 overrun in single mode", 16'(overrun), 16'd1);
    chk("R4 threshold one", 16'(trig_req), 16'd1);
    repeat (5) cyc(0, 11'h0, 0, 1, 0, 0);
    chk("R4 no timeout", 16'(tmo_req), 16'd0);

    // R10: mode change empties
    fifo_en = 1'b1;
    nop();
    chk("R10 mode change flush", 16'(fill_cnt), 16'd0);

    // R3/R1/R9/R11: fill for every threshold
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int k = 0; k < 16; k++) cyc(1, 11'(k * 17 + s), 0, 0, 0, 0);
      chk("R1 sixteen held", 16'(fill_cnt), 16'd16);
      cyc(1, 11'h055, 0, 0, 0, 0);
      chk("R9 full push rejected", 16'(fill_cnt), 16'd16);
      chk("R9 overrun pulse", 16'(overrun), 16'd1);
      nop();
      chk("R9 pulse one cycle", 16'(overrun), 16'd0);
      cyc(1, 11'h066, 1, 0, 0, 0);
      chk("R9 push with pop at full", 16'(fill_cnt), 16'd16);
      for (int k = 0; k < 17; k++) cyc(0, 11'h0, 1, 0, 0, 0);
      chk("R11 pop on empty", 16'(fill_cnt), 16'd0);
      cyc(1, 11'h077, 0, 0, 0, 0);
      chk("R11 push after empty pop", {8'd0, head_data}, 16'h0077);
      cyc(0, 11'h0, 1, 0, 0, 0);
    end

    // R5/R6: idle timeout and restart
    trig_sel = 2'b11;
    cyc(1, 11'h011, 0, 0, 0, 0);
    cyc(1, 11'h022, 0, 0, 0, 0);
    repeat (3) cyc(0, 11'h0, 0, 1, 0, 0);
    cyc(1, 11'h033, 0, 0, 0, 0);
    repeat (3) cyc(0, 11'h0, 0, 1, 0, 0);
    chk("R6 push restarts idle", 16'(tmo_req), 16'd0);
    cyc(0, 11'h0, 0, 1, 0, 0);
    chk("R5 timeout after four", 16'(tmo_req), 16'd1);
    cyc(0, 11'h0, 1, 0, 0, 0);
    chk("R6 pop clears timeout", 16'(tmo_req), 16'd0);
    repeat (2) cyc(0, 11'h0, 1, 0, 0, 0);
    repeat (6) cyc(0, 11'h0, 0, 1, 0, 0);
    chk("R6 empty holds idle", 16'(tmo_req), 16'd0);

    // R7: error flag
    cyc(1, 11'h041, 0, 0, 0, 0);
    cyc(1, 11'h142, 0, 0, 0, 0);
    cyc(1, 11'h043, 0, 0, 0, 0);
    chk("R7 set by errored byte", 16'(err_any), 16'd1);
    cyc(0, 11'h0, 0, 0, 1, 0);
    chk("R7 cleared by status read", 16'(err_any), 16'd0);
    cyc(1, 11'h244, 0, 0, 1, 0);
    chk("R7 set wins over read", 16'(err_any), 16'd1);
    repeat (3) cyc(0, 11'h0, 1, 0, 0, 0);
    chk("R7 kept while errored entry", 16'(err_any), 16'd1);
    cyc(0, 11'h0, 1, 0, 0, 0);
    chk("R7 drops when drained", 16'(err_any), 16'd0);

    // R8: flush
    for (int k = 0; k < 5; k++) cyc(1, 11'h400 | 11'(k), 0, 0, 0, 0);
    cyc(1, 11'h099, 1, 0, 0, 1);
    chk("R8 flush empties", 16'(fill_cnt), 16'd0);
    chk("R8 flush clears error", 16'(err_any), 16'd0);
    nop();
    chk("R8 same-cycle push discarded", 16'(fill_cnt), 16'd0);

    // randomised mix
    for (int n = 0; n < 6000; n++) begin
      logic [10:0] e;
      e = {($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000, 8'($urandom)};
      if ($urandom_range(0, 63) == 0) trig_sel = 2'($urandom);
      if ($urandom_range(0, 700) == 0) fifo_en = ~fifo_en;
      cyc($urandom_range(0, 99) < 45, e, $urandom_range(0, 99) < 35,
          $urandom_range(0, 3) == 0, $urandom_range(0, 15) == 0,
          $urandom_range(0, 400) == 0);
    end
    nop();
    nop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule